// File: doc/BRIEF.md
# Exception Entry and Vector Sequencer

This block turns a request to take an exception into a complete processor redirect. Each request carries an entry class (general, non-maskable interrupt, soft reset or debug), a 5-bit exception code or a debug kind, the current PC, a delay-slot flag, a refill flag, a coprocessor number, and the current status, cause and exception-base register values. One clock edge after the request is sampled, the block drives a one-cycle redirect strobe. In the same cycle it presents the new fetch PC, the updated status and cause words, and the saved return PC together with a write strobe for the exception PC, error PC or debug PC register.

The vector depends on the entry class, the boot-vector status bit, the cause interrupt-vector bit, the refill flag and the exception-level bit. The return PC is the faulting PC, or the PC backed up by one 4-byte instruction when the fault sits in a branch delay slot. A single-step debug entry always saves the plain PC. A small two-state machine sequences the step. ST_IDLE moves to ST_ENTER on a request. ST_ENTER stays in ST_ENTER on a back-to-back request and returns to ST_IDLE otherwise. The redirect strobe is high exactly while the machine is in ST_ENTER.

Top module: `exc_entry_seq`

## Requirements
- R1: A request sampled on a rising edge makes redirect_o high for the following cycle only, unless another request follows. After reset every output is zero.
- R2: For a general entry (class 0) the vector base is 0xBFC00200 when status bit 22 (boot vector) is set, and otherwise the exception base with bits 9:0 cleared. The default offset 0x180 is added to the base.
- R3: A general entry with code 0 (interrupt) while cause bit 23 (interrupt vector) is set uses offset 0x200.
- R4: A general entry with code 2 or 3 (TLB load or store), with refill_i high and status bit 1 (exception level) clear, uses offset 0x000. With the exception level set, it uses 0x180.
- R5: For a general entry with status bit 1 clear, epc_we_o is raised and epc_o is the PC, or the PC minus 4 in a delay slot. Cause bit 31 is set to the slot flag and status bit 1 is set. With status bit 1 already set, epc_we_o stays low and status and cause bit 31 are unchanged.
- R6: A general entry writes the code into cause bits 6:2 and keeps every other cause bit. For code 11 (coprocessor unusable) it also writes cop_i into cause bits 29:28.
- R7: Every entry that saves a return PC clears the mode field, status bits 4:3, so the processor runs in kernel mode.
- R8: Class 1 (non-maskable interrupt) and class 2 (soft reset) raise errpc_we_o with the same delay-slot rule and set status bits 2 (error level) and 22. Class 1 also sets status bit 19 and class 2 sets status bit 20. The new PC is 0xBFC00000, the cause code is kept, and cause bit 31 is cleared when status bit 1 is clear.
- R9: Class 3 (debug) raises dbgpc_we_o and jumps to 0xBFC00480. The saved PC follows the delay-slot rule, except that debug kind 0 (single step) always saves the plain PC. dbg_cause_o has only bit k set for debug kind k in 0..5 (single step, debug interrupt, instruction break, software break, data break store, data break load). Cause bit 31 is cleared when status bit 1 is clear.
- R10: At most one of the three save strobes is high at a time, and a save strobe is high only together with redirect_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Take an exception this cycle |
| class_i | input | 2 | 0 general, 1 non-maskable interrupt, 2 soft reset, 3 debug |
| code_i | input | 5 | Exception code for general entries |
| dbg_kind_i | input | 3 | Debug kind for class 3 |
| pc_i | input | 32 | PC of the faulting instruction |
| in_slot_i | input | 1 | Fault is in a branch delay slot |
| refill_i | input | 1 | TLB miss needs the refill vector |
| cop_i | input | 2 | Coprocessor number for code 11 |
| status_i | input | 32 | Current status register |
| cause_i | input | 32 | Current cause register |
| ebase_i | input | 32 | Current exception base register |
| redirect_o | output | 1 | One-cycle redirect strobe |
| next_pc_o | output | 32 | New fetch PC |
| status_o | output | 32 | Updated status register |
| cause_o | output | 32 | Updated cause register |
| epc_we_o | output | 1 | Write strobe for the exception PC |
| epc_o | output | 32 | Exception PC value |
| errpc_we_o | output | 1 | Write strobe for the error PC |
| errpc_o | output | 32 | Error PC value |
| dbgpc_we_o | output | 1 | Write strobe for the debug PC |
| dbgpc_o | output | 32 | Debug PC value |
| dbg_cause_o | output | 6 | One-hot debug cause bit |

## Verification
The bench goes after the offset choices. An interrupt with the vector bit set under a boot-vector base must land on 0xBFC00400, which a design that ORs the offset onto the base instead of adding it would miss. A refill with the exception level set must fall back to 0x180, and a wrong design would send a nested miss to the refill handler. Delay-slot faults are driven through all three save paths, including a single-step debug entry that must not back up the PC, and a nested general fault that must leave the exception PC, cause bit 31 and status untouched. Back-to-back requests and idle cycles check that the redirect strobe neither merges nor lingers, and the coprocessor field check catches a design that drops cause bits 29:28 or clobbers the neighbouring bits.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int CODE_W    = 5;
    localparam int DK_W      = 3;
    localparam int DBG_KINDS = 6;

    // status bit positions
    localparam int ST_EXL    = 1;
    localparam int ST_ERL    = 2;
    localparam int ST_KSU_LO = 3;
    localparam int ST_KSU_HI = 4;
    localparam int ST_NMI    = 19;
    localparam int ST_SR     = 20;
    localparam int ST_BEV    = 22;

    // cause bit positions
    localparam int CA_CODE_LO = 2;
    localparam int CA_CODE_HI = 6;
    localparam int CA_IV      = 23;
    localparam int CA_CE_LO   = 28;
    localparam int CA_CE_HI   = 29;
    localparam int CA_BD      = 31;

    localparam logic [CODE_W-1:0] EC_INT  = 5'd0;
    localparam logic [CODE_W-1:0] EC_TLBL = 5'd2;
    localparam logic [CODE_W-1:0] EC_TLBS = 5'd3;
    localparam logic [CODE_W-1:0] EC_CPU  = 5'd11;

    localparam logic [DK_W-1:0] DK_SSTEP = 3'd0;

    typedef enum logic [1:0] {
        CLS_GEN  = 2'd0,
        CLS_NMI  = 2'd1,
        CLS_SRST = 2'd2,
        CLS_DBG  = 2'd3
    } exc_class_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ENTER = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic epc;
        logic errpc;
        logic dbgpc;
    } save_sel_t;

endpackage

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          BASE_ALIGN = 10,
    parameter logic [31:0] BOOT_GEN   = 32'hBFC0_0200,
    parameter int          OFF_GEN    = 'h180,
    parameter int          OFF_IRQ    = 'h200,
    parameter int          OFF_REFILL = 'h000
) (
    input  logic [CODE_W-1:0] code,
    input  logic              refill,
    input  logic              exl,
    input  logic              bev,
    input  logic              iv,
    input  logic [XLEN-1:0]   ebase,
    output logic [XLEN-1:0]   vec
);
    localparam logic [XLEN-1:0] ALIGN_MASK = XLEN'((64'd1 << BASE_ALIGN) - 64'd1);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic            is_tlb_miss;

    assign is_tlb_miss = (code == EC_TLBL) || (code == EC_TLBS);

    always_comb begin
        if (is_tlb_miss && refill && !exl) begin
            offset = XLEN'(OFF_REFILL);
        end else if ((code == EC_INT) && iv) begin
            offset = XLEN'(OFF_IRQ);
        end else begin
            offset = XLEN'(OFF_GEN);
        end
    end

    assign base = bev ? XLEN'(BOOT_GEN) : (ebase & ~ALIGN_MASK);
    // adder, not OR: the boot base already has bit 9 set
    assign vec  = base + offset;

endmodule

// File: rtl/exc_return_pc.sv
module exc_return_pc #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic            in_slot,
    input  logic            force_plain,
    output logic [XLEN-1:0] ret_pc
);
    assign ret_pc = (in_slot && !force_plain) ? (pc - XLEN'(INSN_BYTES)) : pc;
endmodule

// File: rtl/exc_state_update.sv
module exc_state_update
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  exc_class_e          cls,
    input  logic [CODE_W-1:0]   code,
    input  logic [DK_W-1:0]     dbg_kind,
    input  logic [1:0]          cop,
    input  logic                in_slot,
    input  logic [XLEN-1:0]     status_in,
    input  logic [XLEN-1:0]     cause_in,
    output logic [XLEN-1:0]     status_out,
    output logic [XLEN-1:0]     cause_out,
    output save_sel_t           save,
    output logic [DBG_KINDS-1:0] dbg_cause
);
    logic exl;
    assign exl = status_in[ST_EXL];

    // one-hot debug cause, one bit per kind
    for (genvar g = 0; g < DBG_KINDS; g++) begin : g_dbg_bit
        assign dbg_cause[g] = (cls == CLS_DBG) && (dbg_kind == DK_W'(g));
    end

    always_comb begin
        status_out = status_in;
        cause_out  = cause_in;
        save       = '0;
        unique case (cls)
            CLS_GEN: begin
                if (!exl) begin
                    save.epc                          = 1'b1;
                    cause_out[CA_BD]                  = in_slot;
                    status_out[ST_EXL]                = 1'b1;
                    status_out[ST_KSU_HI:ST_KSU_LO]   = 2'b00;
                end
                cause_out[CA_CODE_HI:CA_CODE_LO] = code;
                if (code == EC_CPU) begin
                    cause_out[CA_CE_HI:CA_CE_LO] = cop;
                end
            end
            CLS_NMI, CLS_SRST: begin
                save.errpc                      = 1'b1;
                status_out[ST_ERL]              = 1'b1;
                status_out[ST_BEV]              = 1'b1;
                status_out[ST_KSU_HI:ST_KSU_LO] = 2'b00;
                if (cls == CLS_NMI) begin
                    status_out[ST_NMI] = 1'b1;
                end else begin
                    status_out[ST_SR]  = 1'b1;
                end
                if (!exl) begin
                    cause_out[CA_BD] = 1'b0;
                end
            end
            CLS_DBG: begin
                save.dbgpc                      = 1'b1;
                status_out[ST_KSU_HI:ST_KSU_LO] = 2'b00;
                if (!exl) begin
                    cause_out[CA_BD] = 1'b0;
                end
            end
            default: begin
                save = '0;
            end
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          INSN_BYTES = 4,
    parameter int          BASE_ALIGN = 10,
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
    parameter logic [31:0] BOOT_GEN   = 32'hBFC0_0200,
    parameter logic [31:0] DEBUG_VEC  = 32'hBFC0_0480
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [1:0]           class_i,
    input  logic [4:0]           code_i,
    input  logic [2:0]           dbg_kind_i,
    input  logic [XLEN-1:0]      pc_i,
    input  logic                 in_slot_i,
    input  logic                 refill_i,
    input  logic [1:0]           cop_i,
    input  logic [XLEN-1:0]      status_i,
    input  logic [XLEN-1:0]      cause_i,
    input  logic [XLEN-1:0]      ebase_i,
    output logic                 redirect_o,
    output logic [XLEN-1:0]      next_pc_o,
    output logic [XLEN-1:0]      status_o,
    output logic [XLEN-1:0]      cause_o,
    output logic                 epc_we_o,
    output logic [XLEN-1:0]      epc_o,
    output logic                 errpc_we_o,
    output logic [XLEN-1:0]      errpc_o,
    output logic                 dbgpc_we_o,
    output logic [XLEN-1:0]      dbgpc_o,
    output logic [DBG_KINDS-1:0] dbg_cause_o
);
    exc_class_e      cls;
    seq_state_e      state_q, state_d;
    logic [XLEN-1:0] gen_vec;
    logic [XLEN-1:0] ret_pc;
    logic [XLEN-1:0] target_pc;
    logic [XLEN-1:0] status_n;
    logic [XLEN-1:0] cause_n;
    save_sel_t       save;
    logic [DBG_KINDS-1:0] dbg_cause_n;
    logic            plain_pc;

    assign cls      = exc_class_e'(class_i);
    assign plain_pc = (cls == CLS_DBG) && (dbg_kind_i == DK_SSTEP);

    exc_vector_calc #(
        .XLEN      (XLEN),
        .BASE_ALIGN(BASE_ALIGN),
        .BOOT_GEN  (BOOT_GEN)
    ) u_vec (
        .code  (code_i),
        .refill(refill_i),
        .exl   (status_i[ST_EXL]),
        .bev   (status_i[ST_BEV]),
        .iv    (cause_i[CA_IV]),
        .ebase (ebase_i),
        .vec   (gen_vec)
    );

    exc_return_pc #(
        .XLEN      (XLEN),
        .INSN_BYTES(INSN_BYTES)
    ) u_ret (
        .pc         (pc_i),
        .in_slot    (in_slot_i),
        .force_plain(plain_pc),
        .ret_pc     (ret_pc)
    );

    exc_state_update #(
        .XLEN(XLEN)
    ) u_upd (
        .cls       (cls),
        .code      (code_i),
        .dbg_kind  (dbg_kind_i),
        .cop       (cop_i),
        .in_slot   (in_slot_i),
        .status_in (status_i),
        .cause_in  (cause_i),
        .status_out(status_n),
        .cause_out (cause_n),
        .save      (save),
        .dbg_cause (dbg_cause_n)
    );

    always_comb begin
        unique case (cls)
            CLS_GEN:           target_pc = gen_vec;
            CLS_NMI, CLS_SRST: target_pc = XLEN'(RESET_VEC);
            CLS_DBG:           target_pc = XLEN'(DEBUG_VEC);
            default:           target_pc = gen_vec;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_i ? ST_ENTER : ST_IDLE;
            ST_ENTER: state_d = req_i ? ST_ENTER : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign redirect_o = (state_q == ST_ENTER);

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_pc_o   <= '0;
            status_o    <= '0;
            cause_o     <= '0;
            epc_we_o    <= 1'b0;
            epc_o       <= '0;
            errpc_we_o  <= 1'b0;
            errpc_o     <= '0;
            dbgpc_we_o  <= 1'b0;
            dbgpc_o     <= '0;
            dbg_cause_o <= '0;
        end else begin
            epc_we_o    <= 1'b0;
            errpc_we_o  <= 1'b0;
            dbgpc_we_o  <= 1'b0;
            dbg_cause_o <= '0;
            if (req_i) begin
                next_pc_o   <= target_pc;
                status_o    <= status_n;
                cause_o     <= cause_n;
                epc_we_o    <= save.epc;
                errpc_we_o  <= save.errpc;
                dbgpc_we_o  <= save.dbgpc;
                dbg_cause_o <= dbg_cause_n;
                if (save.epc)   epc_o   <= ret_pc;
                if (save.errpc) errpc_o <= ret_pc;
                if (save.dbgpc) dbgpc_o <= ret_pc;
            end
        end
    end

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int          XLEN      = 32,
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
    parameter logic [31:0] DEBUG_VEC = 32'hBFC0_0480
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_i,
    input logic [1:0]      class_i,
    input logic [2:0]      dbg_kind_i,
    input logic [XLEN-1:0] pc_i,
    input logic            in_slot_i,
    input logic [XLEN-1:0] status_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic [XLEN-1:0] status_o,
    input logic            epc_we_o,
    input logic            errpc_we_o,
    input logic [XLEN-1:0] errpc_o,
    input logic            dbgpc_we_o,
    input logic [5:0]      dbg_cause_o
);
    p_redirect_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> redirect_o);

    p_no_stray_redirect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !redirect_o);

    p_exl_blocks_epc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && class_i == 2'd0 && status_i[1]) |=> !epc_we_o);

    p_kernel_on_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (epc_we_o || errpc_we_o || dbgpc_we_o) |-> (status_o[4:3] == 2'b00));

    p_reset_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (class_i == 2'd1 || class_i == 2'd2)) |=>
            (next_pc_o == XLEN'(RESET_VEC) && status_o[2] && errpc_we_o));

    p_errpc_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && class_i == 2'd1 && in_slot_i) |=> (errpc_o == $past(pc_i) - XLEN'(4)));

    p_debug_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && class_i == 2'd3 && dbg_kind_i < 3'd6) |=>
            (next_pc_o == XLEN'(DEBUG_VEC) && $countones(dbg_cause_o) == 1));

    p_one_save_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({epc_we_o, errpc_we_o, dbgpc_we_o}));

    p_save_with_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (epc_we_o || errpc_we_o || dbgpc_we_o) |-> redirect_o);

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
    .XLEN     (XLEN),
    .RESET_VEC(RESET_VEC),
    .DEBUG_VEC(DEBUG_VEC)
) u_chk (.*);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  class_i = '0;
    logic [4:0]  code_i = '0;
    logic [2:0]  dbg_kind_i = '0;
    logic [31:0] pc_i = '0;
    logic        in_slot_i = 1'b0;
    logic        refill_i = 1'b0;
    logic [1:0]  cop_i = '0;
    logic [31:0] status_i = '0;
    logic [31:0] cause_i = '0;
    logic [31:0] ebase_i = '0;
    logic        redirect_o;
    logic [31:0] next_pc_o, status_o, cause_o, epc_o, errpc_o, dbgpc_o;
    logic        epc_we_o, errpc_we_o, dbgpc_we_o;
    logic [5:0]  dbg_cause_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_seq dut_i (.*);

    typedef struct {
        bit          redir;
        logic [31:0] pc, st, ca, epc, errpc, dbgpc;
        bit          ew, rw, dw;
        logic [5:0]  dc;
        logic [31:0] tag;
    } exp_t;

    exp_t q[$];

    task automatic chk(input bit ok, input logic [31:0] tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input int cls, input logic [4:0] code, input logic [2:0] dk,
                                   input logic [31:0] pc, input bit slot, input bit refill,
                                   input logic [1:0] cop, input logic [31:0] st,
                                   input logic [31:0] ca, input logic [31:0] eb,
                                   input logic [31:0] tag);
        exp_t e;
        logic [31:0] ret, base, off;
        bit exl;
        e = '{redir: 1'b1, pc: '0, st: st, ca: ca, epc: '0, errpc: '0, dbgpc: '0,
              ew: 1'b0, rw: 1'b0, dw: 1'b0, dc: '0, tag: tag};
        ret = slot ? pc - 32'd4 : pc;
        exl = st[1];
        if (cls == 0) begin
            off = 32'h180;
            if (code == 5'd0 && ca[23]) off = 32'h200;
            if ((code == 5'd2 || code == 5'd3) && refill && !exl) off = 32'h0;
            base = st[22] ? 32'hBFC00200 : {eb[31:10], 10'b0};
            e.pc = base + off;
            if (!exl) begin
                e.ew = 1'b1; e.epc = ret;
                e.ca[31] = slot; e.st[1] = 1'b1; e.st[4:3] = 2'b00;
            end
            e.ca[6:2] = code;
            if (code == 5'd11) e.ca[29:28] = cop;
        end else if (cls == 1 || cls == 2) begin
            e.rw = 1'b1; e.errpc = ret;
            e.st[2] = 1'b1; e.st[22] = 1'b1; e.st[4:3] = 2'b00;
            if (cls == 1) e.st[19] = 1'b1; else e.st[20] = 1'b1;
            if (!exl) e.ca[31] = 1'b0;
            e.pc = 32'hBFC00000;
        end else begin
            e.dw = 1'b1; e.dbgpc = (dk == 3'd0) ? pc : ret;
            e.dc = (dk < 3'd6) ? (6'd1 << dk) : 6'd0;
            e.st[4:3] = 2'b00;
            if (!exl) e.ca[31] = 1'b0;
            e.pc = 32'hBFC00480;
        end
        return e;
    endfunction

    task automatic send(input int cls, input logic [4:0] code, input logic [2:0] dk,
                        input logic [31:0] pc, input bit slot, input bit refill,
                        input logic [1:0] cop, input logic [31:0] st,
                        input logic [31:0] ca, input logic [31:0] eb,
                        input logic [31:0] tag);
        @(negedge clk);
        req_i = 1'b1; class_i = 2'(cls); code_i = code; dbg_kind_i = dk; pc_i = pc;
        in_slot_i = slot; refill_i = refill; cop_i = cop;
        status_i = st; cause_i = ca; ebase_i = eb;
        q.push_back(model(cls, code, dk, pc, slot, refill, cop, st, ca, eb, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            @(negedge clk);
            req_i = 1'b0;
            pc_i = 32'hDEAD0000 + 32'(i);
            e = '{redir: 1'b0, pc: '0, st: '0, ca: '0, epc: '0, errpc: '0, dbgpc: '0,
                  ew: 1'b0, rw: 1'b0, dw: 1'b0, dc: '0, tag: "R1"};
            q.push_back(e);
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(redirect_o == e.redir, e.tag, "redirect", 32'(redirect_o), 32'(e.redir));
                if (e.redir) begin
                    chk(next_pc_o == e.pc, e.tag, "next_pc", next_pc_o, e.pc);
                    chk(status_o == e.st, e.tag, "status", status_o, e.st);
                    chk(cause_o == e.ca, e.tag, "cause", cause_o, e.ca);
                    chk(epc_we_o == e.ew, e.tag, "epc_we", 32'(epc_we_o), 32'(e.ew));
                    chk(errpc_we_o == e.rw, e.tag, "errpc_we", 32'(errpc_we_o), 32'(e.rw));
                    chk(dbgpc_we_o == e.dw, e.tag, "dbgpc_we", 32'(dbgpc_we_o), 32'(e.dw));
                    if (e.ew) chk(epc_o == e.epc, e.tag, "epc", epc_o, e.epc);
                    if (e.rw) chk(errpc_o == e.errpc, e.tag, "errpc", errpc_o, e.errpc);
                    if (e.dw) begin
                        chk(dbgpc_o == e.dbgpc, e.tag, "dbgpc", dbgpc_o, e.dbgpc);
                        chk(dbg_cause_o == e.dc, e.tag, "dbg_cause", 32'(dbg_cause_o), 32'(e.dc));
                    end
                end else begin
                    // R10: no save strobe without a redirect
                    chk({epc_we_o, errpc_we_o, dbgpc_we_o} == 3'b000, "R10", "idle strobes",
                        32'({epc_we_o, errpc_we_o, dbgpc_we_o}), 32'd0);
                end
            end
        end
    end

    // watchdog
    initial begin
        #200000;
        if (!done) begin
            bad++; total++;
            $display("FAIL R1 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] st_k, st_k_exl;
        st_k     = 32'h0000_0010;           // mode bits 4:3 = 2'b10, EXL clear
        st_k_exl = 32'h0000_0012;           // same with EXL set
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(redirect_o == 1'b0 && next_pc_o == 32'd0 && status_o == 32'd0, "R1", "reset outputs",
            next_pc_o, 32'd0);
        chk({epc_we_o, errpc_we_o, dbgpc_we_o} == 3'b000 && dbg_cause_o == 6'd0, "R1",
            "reset strobes", 32'({epc_we_o, errpc_we_o, dbgpc_we_o}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R5 R6 R7: syscall, ebase base, not in slot
        send(0, 5'd8, 3'd0, 32'h0040_1000, 1'b0, 1'b0, 2'd0, st_k, 32'h0000_0300, 32'h8000_1234, "R2");
        // R5 delay slot backs up PC, sets BD
        send(0, 5'd10, 3'd0, 32'h0040_2004, 1'b1, 1'b0, 2'd0, st_k, 32'h0000_0000, 32'h8000_0000, "R5");
        idle(2);
        // R2 boot vector base
        send(0, 5'd12, 3'd0, 32'h0000_0100, 1'b0, 1'b0, 2'd0, 32'h0040_0000, 32'h0, 32'h9000_0000, "R2");
        // R3 interrupt with vector bit, boot base -> 0xBFC00400
        send(0, 5'd0, 3'd0, 32'h0000_0200, 1'b0, 1'b0, 2'd0, 32'h0040_0000, 32'h0080_0000, 32'h0, "R3");
        // R3 interrupt with vector bit clear -> 0x180
        send(0, 5'd0, 3'd0, 32'h0000_0200, 1'b0, 1'b0, 2'd0, st_k, 32'h0, 32'h8000_0000, "R3");
        idle(1);
        // R4 refill load miss, EXL clear -> offset 0
        send(0, 5'd2, 3'd0, 32'h0000_3000, 1'b0, 1'b1, 2'd0, st_k, 32'h0, 32'h8000_0000, "R4");
        // R4 refill store miss with EXL set -> 0x180, no EPC, BD kept
        send(0, 5'd3, 3'd0, 32'h0000_3004, 1'b1, 1'b1, 2'd0, st_k_exl, 32'h8000_0000, 32'h8000_0000, "R4");
        // R4 store miss without refill, EXL clear -> 0x180
        send(0, 5'd3, 3'd0, 32'h0000_3008, 1'b0, 1'b0, 2'd0, st_k, 32'h0, 32'h8000_0000, "R4");
        idle(1);
        // R6 coprocessor unusable field
        send(0, 5'd11, 3'd0, 32'h0000_4000, 1'b0, 1'b0, 2'd2, st_k, 32'h1000_0000, 32'h8000_0000, "R6");
        // R8 non-maskable interrupt in slot
        send(1, 5'd0, 3'd0, 32'h0000_5004, 1'b1, 1'b0, 2'd0, st_k, 32'h8000_0024, 32'h8000_0000, "R8");
        // R8 soft reset, EXL set keeps BD
        send(2, 5'd0, 3'd0, 32'h0000_6000, 1'b0, 1'b0, 2'd0, st_k_exl, 32'h8000_0000, 32'h8000_0000, "R8");
        idle(2);
        // R9 single step in slot saves plain PC
        send(3, 5'd0, 3'd0, 32'h0000_7004, 1'b1, 1'b0, 2'd0, st_k, 32'h8000_0000, 32'h0, "R9");
        // R9 data break store in slot backs up PC
        send(3, 5'd0, 3'd4, 32'h0000_7104, 1'b1, 1'b0, 2'd0, st_k, 32'h0, 32'h0, "R9");
        // R9 debug interrupt, not in slot
        send(3, 5'd0, 3'd1, 32'h0000_7200, 1'b0, 1'b0, 2'd0, st_k_exl, 32'h8000_0000, 32'h0, "R9");
        idle(1);
        // R1 R7 back-to-back general entries, then idle
        send(0, 5'd9, 3'd0, 32'h0000_8000, 1'b0, 1'b0, 2'd0, st_k, 32'h0, 32'h8000_0800, "R7");
        send(0, 5'd13, 3'd0, 32'h0000_8004, 1'b1, 1'b0, 2'd0, st_k, 32'h0, 32'h8000_0800, "R1");
        idle(3);

        wait (q.size() == 0);
        @(posedge clk);
        #1;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule